// File: doc/BRIEF.md
# Pulse-Swallowing Pilot-Synchronous Sampling Clock Generator

This block produces a sampling-clock enable at 512 times the 19 kHz stereo pilot rate from a fixed, faster master clock. It uses no analog PLL. A phase accumulator adds an increment on every master cycle, and each carry out becomes one sampling enable. Master cycles that do not produce a carry are skipped, so the output is a gapped, non-continuous clock. At the default parameters the nominal increment gives 9.728 MHz from a 36.864 MHz master.

An external pilot loop steers the rate with single-cycle up and down correction pulses. Each pulse moves the increment by a fixed step, and the increment is confined to a window around the nominal value. When no pilot is present, the pulses stop and the rate stays wherever the loop left it. When the preset control is high, the increment is forced back to nominal on every cycle and the correction pulses have no effect. This mode is used for AM, tape/auxiliary and digital sources.

The block also produces a core frame strobe. In internal mode it is one pulse for every 256 sampling enables. When an external serial-audio source is selected, the strobe instead follows the rising edges of that source's word-select signal, which is synchronised into the master clock domain first.

Top module: `swallow_clk_gen`

## Requirements
- R1: While `rstN` is low, `sampleEn` and `frameSync` are 0; the increment is nominal (`NOM_INC`) and the accumulator is cleared.
- R2: With a steady increment, any run of 2^`ACC_W` consecutive master cycles contains exactly as many `sampleEn` pulses as the increment value.
- R3: `sampleEn` is never high in two consecutive master cycles.
- R4: With `presetMode` low, a one-cycle `corrUp` pulse raises the increment by `STEP`, and a one-cycle `corrDn` pulse lowers it by `STEP`.
- R5: The increment never leaves the range `NOM_INC`-`MAX_DEV` to `NOM_INC`+`MAX_DEV`. A step that would leave this range is not taken.
- R6: If `corrUp` and `corrDn` are high in the same cycle, the increment does not change.
- R7: While `presetMode` is high, the increment is reloaded to `NOM_INC` on every cycle and the correction pulses are ignored.
- R8: With `extSrcSel` low, `frameSync` is a one-cycle pulse in the cycle right after every `DIV`-th `sampleEn`, counted from reset. Exactly `DIV` enables separate two consecutive strobes.
- R9: With `extSrcSel` high, each rising edge of `extWs` yields exactly one `frameSync` pulse, in the third master cycle after the first rising clock edge that samples `extWs` high. Falling edges yield nothing, and the internal divided strobe is suppressed.
- R10: With `presetMode` low and no correction pulses, the increment, and so the sampling rate, holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| corrUp | input | 1 | Pilot-loop request to raise the rate (one step per cycle high) |
| corrDn | input | 1 | Pilot-loop request to lower the rate (one step per cycle high) |
| presetMode | input | 1 | Hold the rate at nominal and ignore corrections |
| extSrcSel | input | 1 | Select the external word-select as frame sync source |
| extWs | input | 1 | Word-select of the external serial audio source (asynchronous) |
| sampleEn | output | 1 | Gapped sampling-clock enable |
| frameSync | output | 1 | One-cycle core frame synchronisation strobe |

## Verification
The assertions assume that the correction inputs are synchronous to the master clock and that the increment bound stays below half the accumulator range. Together these make every enable a single isolated cycle. They also assume that `extWs` stays stable for several master cycles between edges, so that the synchroniser never has to merge two edges. The stimulus drives the correction pulses on the falling clock edge, each one cycle long and separated by an idle cycle. It uses bench parameters whose bound stays well below half range, and it holds `extWs` at each level for tens of cycles.

// File: rtl/swallow_pkg.sv
package swallow_pkg;

  // Strobes passed from control to datapath every master cycle
  typedef struct packed {
    logic loadNom;   // force increment to nominal
    logic stepUp;    // raise increment by one step
    logic stepDn;    // lower increment by one step
    logic wsEdge;    // synchronised rising edge of external word-select
    logic useExt;    // frame sync taken from external edge
  } swCtrl_t;

endpackage

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
  import swallow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    corrUp,
  input  logic    corrDn,
  input  logic    presetMode,
  input  logic    extSrcSel,
  input  logic    extWs,
  output swCtrl_t ctrlStb
);

  localparam int PIPE_LEN = SYNC_STAGES + 1;

  // Synchroniser stages plus one history flop for edge detection
  logic [PIPE_LEN-1:0] wsPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wsPipe <= '0;
    else       wsPipe <= {wsPipe[PIPE_LEN-2:0], extWs};
  end

  logic wsRise;
  assign wsRise = wsPipe[SYNC_STAGES-1] & ~wsPipe[SYNC_STAGES];

  always_comb begin
    ctrlStb.loadNom = presetMode;
    ctrlStb.stepUp  = corrUp & ~corrDn & ~presetMode;
    ctrlStb.stepDn  = corrDn & ~corrUp & ~presetMode;
    ctrlStb.wsEdge  = wsRise;
    ctrlStb.useExt  = extSrcSel;
  end

  // R6 R7: at most one increment action is requested per cycle
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrlStb.loadNom, ctrlStb.stepUp, ctrlStb.stepDn}));

  // R9
  ws_edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.wsEdge |=> !ctrlStb.wsEdge);

endmodule

// File: rtl/swallow_dp.sv
module swallow_dp
  import swallow_pkg::*;
#(
  parameter int ACC_W   = 16,
  parameter int NOM_INC = 17294,
  parameter int STEP    = 1,
  parameter int MAX_DEV = 64,
  parameter int DIV     = 256
) (
  input  logic    clk,
  input  logic    rstN,
  input  swCtrl_t ctrlStb,
  output logic    sampleEn,
  output logic    frameSync
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [ACC_W-1:0] INC_NOM  = ACC_W'(NOM_INC);
  localparam logic [ACC_W-1:0] INC_STEP = ACC_W'(STEP);
  localparam logic [ACC_W-1:0] INC_MAX  = ACC_W'(NOM_INC + MAX_DEV);
  localparam logic [ACC_W-1:0] INC_MIN  = ACC_W'(NOM_INC - MAX_DEV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [ACC_W-1:0] incReg;
  logic [ACC_W-1:0] accReg;
  logic [ACC_W:0]   accSum;
  logic [DIV_W-1:0] divCnt;
  logic             intStrobe;

  // Increment register: preset reload, bounded up/down steps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incReg <= INC_NOM;
    end else if (ctrlStb.loadNom) begin
      incReg <= INC_NOM;
    end else if (ctrlStb.stepUp && (incReg <= INC_MAX - INC_STEP)) begin
      incReg <= incReg + INC_STEP;
    end else if (ctrlStb.stepDn && (incReg >= INC_MIN + INC_STEP)) begin
      incReg <= incReg - INC_STEP;
    end
  end

  // Phase accumulator: carry out becomes the sampling enable
  assign accSum = {1'b0, accReg} + {1'b0, incReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg   <= '0;
      sampleEn <= 1'b0;
    end else begin
      accReg   <= accSum[ACC_W-1:0];
      sampleEn <= accSum[ACC_W];
    end
  end

  // Frame divider over sampling enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (sampleEn) divCnt <= (divCnt == DIV_LAST) ? '0 : divCnt + 1'b1;
  end

  assign intStrobe = sampleEn && (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameSync <= 1'b0;
    else       frameSync <= ctrlStb.useExt ? ctrlStb.wsEdge : intStrobe;
  end

  // R3
  no_double_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |=> !sampleEn);

  // R5
  inc_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incReg >= INC_MIN) && (incReg <= INC_MAX));

  // R7
  preset_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.loadNom |=> (incReg == INC_NOM));

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb.stepUp && (incReg <= INC_MAX - INC_STEP))
      |=> (incReg == $past(incReg) + INC_STEP));

  // R8
  int_sync_after_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && !$past(ctrlStb.useExt)) |-> $past(sampleEn));

endmodule

// File: rtl/swallow_clk_gen.sv
module swallow_clk_gen
  import swallow_pkg::*;
#(
  parameter int ACC_W       = 16,
  parameter int NOM_INC     = 17294,
  parameter int STEP        = 1,
  parameter int MAX_DEV     = 64,
  parameter int DIV         = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic corrUp,
  input  logic corrDn,
  input  logic presetMode,
  input  logic extSrcSel,
  input  logic extWs,
  output logic sampleEn,
  output logic frameSync
);

  swCtrl_t ctrlStb;

  swallow_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .corrUp    (corrUp),
    .corrDn    (corrDn),
    .presetMode(presetMode),
    .extSrcSel (extSrcSel),
    .extWs     (extWs),
    .ctrlStb   (ctrlStb)
  );

  swallow_dp #(
    .ACC_W  (ACC_W),
    .NOM_INC(NOM_INC),
    .STEP   (STEP),
    .MAX_DEV(MAX_DEV),
    .DIV    (DIV)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlStb  (ctrlStb),
    .sampleEn (sampleEn),
    .frameSync(frameSync)
  );

endmodule

// File: tb/swallow_clk_gen_tb_top.sv
`timescale 1ns/1ps
module swallow_clk_gen_tb_top;

  localparam int TB_ACC  = 12;
  localparam int TB_NOM  = 1081;
  localparam int TB_STEP = 2;
  localparam int TB_DEV  = 32;
  localparam int TB_DIV  = 256;
  localparam int WIN     = 1 << TB_ACC;

  logic clk = 1'b0;
  logic rstN, corrUp, corrDn, presetMode, extSrcSel, extWs;
  logic sampleEn, frameSync;

  always #2.5 clk = ~clk;

  swallow_clk_gen #(
    .ACC_W(TB_ACC), .NOM_INC(TB_NOM), .STEP(TB_STEP),
    .MAX_DEV(TB_DEV), .DIV(TB_DIV), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rstN(rstN), .corrUp(corrUp), .corrDn(corrDn),
    .presetMode(presetMode), .extSrcSel(extSrcSel), .extWs(extWs),
    .sampleEn(sampleEn), .frameSync(frameSync)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  bit monOn   = 0;
  bit doubleSeen = 0;
  bit prevEn  = 0;
  bit finished = 0;
  int expQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Enable run tracker for R3
  always @(negedge clk) begin
    if (rstN && sampleEn && prevEn) doubleSeen = 1;
    prevEn = sampleEn;
  end

  // Scoreboard monitor for external frame sync (R9)
  always @(negedge clk) begin
    if (monOn && frameSync) begin
      if (expQ.size() == 0) check(0, "R9 unexpected frameSync", cyc, -1);
      else begin
        int e;
        e = expQ.pop_front();
        check(cyc == e, "R9 frameSync cycle", cyc, e);
      end
    end
  end

  task automatic pulse(input bit up, input bit dn, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); corrUp = up; corrDn = dn;
      @(negedge clk); corrUp = 0; corrDn = 0;
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic countWin(output int n);
    n = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (sampleEn) n++;
    end
  endtask

  task automatic waitFrame(output int n);
    n = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (frameSync) return;
      if (sampleEn) n++;
    end
    n = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", cyc, 150000);
    finishRun();
  end

  initial begin
    int n;
    rstN = 0; corrUp = 0; corrDn = 0; presetMode = 1; extSrcSel = 0; extWs = 0;
    repeat (5) @(negedge clk);
    check(sampleEn == 0, "R1 sampleEn in reset", sampleEn, 0);
    check(frameSync == 0, "R1 frameSync in reset", frameSync, 0);
    rstN = 1;

    // R8: enables per frame from reset, then between strobes
    waitFrame(n);
    check(n == TB_DIV, "R8 first frame enables", n, TB_DIV);
    waitFrame(n);
    check(n == TB_DIV, "R8 frame interval", n, TB_DIV);
    waitFrame(n);
    check(n == TB_DIV, "R8 frame interval 2", n, TB_DIV);

    // R2 R1: nominal rate in preset
    countWin(n);
    check(n == TB_NOM, "R2 nominal window", n, TB_NOM);

    // R7: corrections ignored in preset
    pulse(1, 0, 20); settle();
    countWin(n);
    check(n == TB_NOM, "R7 ups ignored in preset", n, TB_NOM);

    // R10: loop mode, no pulses keeps nominal
    presetMode = 0; settle();
    countWin(n);
    check(n == TB_NOM, "R10 free-run nominal", n, TB_NOM);

    // R4 steps
    pulse(1, 0, 5); settle();
    countWin(n);
    check(n == TB_NOM + 5*TB_STEP, "R4 up steps", n, TB_NOM + 5*TB_STEP);
    pulse(0, 1, 3); settle();
    countWin(n);
    check(n == TB_NOM + 2*TB_STEP, "R4 down steps", n, TB_NOM + 2*TB_STEP);

    // R6 simultaneous
    pulse(1, 1, 10); settle();
    countWin(n);
    check(n == TB_NOM + 2*TB_STEP, "R6 up and down together", n, TB_NOM + 2*TB_STEP);

    // R10 hold after corrections
    countWin(n);
    check(n == TB_NOM + 2*TB_STEP, "R10 holds offset", n, TB_NOM + 2*TB_STEP);

    // R5 bounds
    pulse(1, 0, 40); settle();
    countWin(n);
    check(n == TB_NOM + TB_DEV, "R5 upper bound", n, TB_NOM + TB_DEV);
    pulse(0, 1, 80); settle();
    countWin(n);
    check(n == TB_NOM - TB_DEV, "R5 lower bound", n, TB_NOM - TB_DEV);

    // R7 reload
    presetMode = 1; settle();
    countWin(n);
    check(n == TB_NOM, "R7 preset reload", n, TB_NOM);

    // R3
    check(doubleSeen == 0, "R3 consecutive enables", doubleSeen, 0);

    // R9: external word-select edges
    @(negedge clk); extSrcSel = 1;
    settle();
    monOn = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); extWs = 1; expQ.push_back(cyc + 3);
      repeat (30) @(negedge clk);
      extWs = 0;
      repeat (30) @(negedge clk);
    end
    repeat (2500) @(negedge clk);
    monOn = 0;
    check(expQ.size() == 0, "R9 missing frameSync", expQ.size(), 0);

    finishRun();
  end

endmodule